// File: doc/BRIEF.md
# Two-Stage Bus Watchdog Timer

This block is a watchdog counter that sits on a simple single-cycle 32-bit register bus. Software chooses one of sixteen timeout periods, where period index `i` lasts `2^(BASE_EXP+i)` clock cycles. `BASE_EXP` is 16 by default. Software then enables the block, and from that point on it must write a fixed restart code at regular intervals. If the counter reaches the end of a period, the block responds in one of two ways:

- **Direct mode:** it drives a system reset pulse at once.
- **Warning mode:** it first raises an interrupt. It issues the reset pulse only if a second full period also runs out with no restart.

Once enabled, the watchdog cannot be turned off. It keeps counting after every reset pulse until the block itself is reset.

The behaviour is a four-state machine:

| State | Meaning | Outputs |
|---|---|---|
| `ST_IDLE` | Disabled | Both outputs low |
| `ST_RUN` | Counting the first stage | Both outputs low |
| `ST_WARN` | Interrupt pending, counting the second stage | Interrupt high |
| `ST_PULSE` | Reset output active | Reset high |

The state transitions are:

| From | To | Condition |
|---|---|---|
| `ST_IDLE` | `ST_RUN` | Enable rises |
| `ST_RUN` | `ST_RUN` | Restart (reload) |
| `ST_RUN` | `ST_WARN` | Expiry in warning mode |
| `ST_RUN` | `ST_PULSE` | Expiry in direct mode |
| `ST_WARN` | `ST_RUN` | Restart, or interrupt clear |
| `ST_WARN` | `ST_PULSE` | Second expiry |
| `ST_PULSE` | `ST_RUN` | Pulse finished |

Bus access rules:

- A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high.
- Read data is combinational while `bus_sel` is high and `bus_wr` is low.
- A read of the clear offset takes its side effect at that same edge.

Top module: `guard_timer`

## Requirements
- R1: After reset the block is in `ST_IDLE`. Both outputs are low, and the control, range, count and status registers all read 0.
- R2: The control register is at 0x00, with bit 0 = enable and bit 1 = mode (1 = warning mode, 0 = direct mode). The enable bit is sticky: writing 0 to bit 0 leaves it set. The mode bit is freely writable, and the register reads back {mode, enable}.
- R3: When enable goes 0→1, the counter loads `2^(BASE_EXP+k)-1`, where k is the initial-period field (bits 7:4 of the range register at 0x04). It then decrements by one each cycle, and its value reads at 0x08.
- R4: In direct mode, expiry comes exactly one period after the load. The reset output then stays high for `PULSE_LEN` cycles. After that, the counter reloads with the running period (range bits 3:0) and counting resumes.
- R5: A write of exactly 0x00000076 to 0x0C reloads the running period and, in `ST_WARN`, drops the interrupt and returns to the first stage. Any other value written there has no effect.
- R6: In warning mode, the first expiry raises the interrupt and reloads the running period. A second expiry with no restart in between ends the interrupt and starts the reset pulse. The interrupt status reads as bit 0 of 0x10.
- R7: A write or a read at 0x14 drops a pending interrupt and returns to the first stage without reloading. A read there returns the status as it was before the clear.
- R8: When events fall in the same cycle, the priority is restart first, then expiry, then interrupt clear.
- R9: The range register at 0x04 reads back bits 7:0 as written. Offset 0xF4 reads 0x00000040 (bit 6 set: fixed periods). Writes to read-only offsets have no effect, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous block reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read access |
| wdt_rst_o | output | 1 | System reset pulse |
| wdt_irq_o | output | 1 | Warning interrupt |

## Verification
Two pairs of events can coincide, and both are provoked with directed tests.

- **Restart with expiry:** the restart write is timed so that its clock edge is the exact edge on which the counter would expire. The check is that the reset output stays low and a full new period follows.
- **Clear with second expiry:** in warning mode, the interrupt clear is timed to land on the second-stage expiry edge. The check is that the reset pulse starts anyway, because expiry outranks clear.

All edges are counted from the enabling write, so the expected cycle for each event is fixed in advance.

// File: rtl/guard_pkg.sv
package guard_pkg;
    localparam int BUS_AW = 8;
    localparam int BUS_DW = 32;

    localparam logic [BUS_AW-1:0] OFS_CTRL  = 8'h00;
    localparam logic [BUS_AW-1:0] OFS_RANGE = 8'h04;
    localparam logic [BUS_AW-1:0] OFS_COUNT = 8'h08;
    localparam logic [BUS_AW-1:0] OFS_KICK  = 8'h0C;
    localparam logic [BUS_AW-1:0] OFS_STAT  = 8'h10;
    localparam logic [BUS_AW-1:0] OFS_CLR   = 8'h14;
    localparam logic [BUS_AW-1:0] OFS_PARAM = 8'hF4;

    localparam logic [BUS_DW-1:0] KICK_CODE  = 32'h0000_0076;
    localparam logic [BUS_DW-1:0] PARAM_WORD = 32'h0000_0040;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_WARN  = 2'd2,
        ST_PULSE = 2'd3
    } guard_state_e;
endpackage

// File: rtl/guard_bus_regs.sv
module guard_bus_regs
    import guard_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              irq,
    output logic              en,
    output logic              mode,
    output logic [IDX_W-1:0]  run_idx,
    output logic [IDX_W-1:0]  init_idx,
    output logic              en_rise,
    output logic              kick,
    output logic              clr
);
    logic wr_acc, rd_acc;
    logic en_q, mode_q;
    logic [IDX_W-1:0] run_q, init_q;

    assign wr_acc = bus_sel && bus_wr;
    assign rd_acc = bus_sel && !bus_wr;

    assign en_rise = wr_acc && (bus_addr == OFS_CTRL) && bus_wdata[0] && !en_q;
    assign kick    = wr_acc && (bus_addr == OFS_KICK) && (bus_wdata == KICK_CODE);
    assign clr     = bus_sel && (bus_addr == OFS_CLR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mode_q <= 1'b0;
            run_q  <= '0;
            init_q <= '0;
        end else if (wr_acc) begin
            if (bus_addr == OFS_CTRL) begin
                en_q   <= en_q | bus_wdata[0];
                mode_q <= bus_wdata[1];
            end
            if (bus_addr == OFS_RANGE) begin
                run_q  <= bus_wdata[IDX_W-1:0];
                init_q <= bus_wdata[2*IDX_W-1:IDX_W];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_acc) begin
            case (bus_addr)
                OFS_CTRL:         bus_rdata = BUS_DW'({mode_q, en_q});
                OFS_RANGE:        bus_rdata = BUS_DW'({init_q, run_q});
                OFS_COUNT:        bus_rdata = BUS_DW'(cnt);
                OFS_STAT, OFS_CLR: bus_rdata = BUS_DW'(irq);
                OFS_PARAM:        bus_rdata = PARAM_WORD;
                default:          bus_rdata = '0;
            endcase
        end
    end

    assign en       = en_q;
    assign mode     = mode_q;
    assign run_idx  = run_q;
    assign init_idx = init_q;
endmodule

// File: rtl/guard_countdown.sv
module guard_countdown #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign cnt  = cnt_q;
    assign zero = (cnt_q == '0);
endmodule

// File: rtl/guard_resp_fsm.sv
module guard_resp_fsm
    import guard_pkg::*;
#(
    parameter int IDX_W     = 4,
    parameter int CNT_W     = 32,
    parameter int BASE_EXP  = 16,
    parameter int PULSE_LEN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_rise,
    input  logic             kick,
    input  logic             clr,
    input  logic             mode,
    input  logic [IDX_W-1:0] run_idx,
    input  logic [IDX_W-1:0] init_idx,
    input  logic             zero,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             wdt_rst_o,
    output logic             wdt_irq_o
);
    localparam logic [CNT_W-1:0] PULSE_LOAD = CNT_W'(PULSE_LEN - 1);

    guard_state_e state_q, state_d;

    function automatic logic [CNT_W-1:0] span(input logic [IDX_W-1:0] idx);
        return (CNT_W'(1) << (BASE_EXP + int'(idx))) - CNT_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (en_rise) begin
                    state_d  = ST_RUN;
                    load     = 1'b1;
                    load_val = span(init_idx);
                end
            end
            ST_RUN: begin
                if (kick) begin
                    load     = 1'b1;
                    load_val = span(run_idx);
                end else if (zero) begin
                    load = 1'b1;
                    if (mode) begin
                        state_d  = ST_WARN;
                        load_val = span(run_idx);
                    end else begin
                        state_d  = ST_PULSE;
                        load_val = PULSE_LOAD;
                    end
                end
            end
            ST_WARN: begin
                if (kick) begin
                    state_d  = ST_RUN;
                    load     = 1'b1;
                    load_val = span(run_idx);
                end else if (zero) begin
                    state_d  = ST_PULSE;
                    load     = 1'b1;
                    load_val = PULSE_LOAD;
                end else if (clr) begin
                    state_d = ST_RUN;
                end
            end
            ST_PULSE: begin
                if (zero) begin
                    state_d  = ST_RUN;
                    load     = 1'b1;
                    load_val = span(run_idx);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        wdt_rst_o = 1'b0;
        wdt_irq_o = 1'b0;
        unique case (state_q)
            ST_WARN:  wdt_irq_o = 1'b1;
            ST_PULSE: wdt_rst_o = 1'b1;
            default: begin
                wdt_rst_o = 1'b0;
                wdt_irq_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/guard_timer.sv
module guard_timer
    import guard_pkg::*;
#(
    parameter int NUM_PERIODS = 16,
    parameter int BASE_EXP    = 16,
    parameter int PULSE_LEN   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              wdt_rst_o,
    output logic              wdt_irq_o
);
    localparam int IDX_W = $clog2(NUM_PERIODS);
    localparam int CNT_W = BASE_EXP + NUM_PERIODS;

    logic             ctrl_en, ctrl_mode, en_rise, kick, clr, zero, load;
    logic [IDX_W-1:0] run_idx, init_idx;
    logic [CNT_W-1:0] cnt_val, load_val;

    guard_bus_regs #(.IDX_W(IDX_W), .CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt(cnt_val), .irq(wdt_irq_o), .en(ctrl_en), .mode(ctrl_mode),
        .run_idx(run_idx), .init_idx(init_idx), .en_rise(en_rise),
        .kick(kick), .clr(clr)
    );

    guard_countdown #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
        .cnt(cnt_val), .zero(zero)
    );

    guard_resp_fsm #(
        .IDX_W(IDX_W), .CNT_W(CNT_W), .BASE_EXP(BASE_EXP), .PULSE_LEN(PULSE_LEN)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .en_rise(en_rise), .kick(kick), .clr(clr),
        .mode(ctrl_mode), .run_idx(run_idx), .init_idx(init_idx), .zero(zero),
        .load(load), .load_val(load_val), .wdt_rst_o(wdt_rst_o), .wdt_irq_o(wdt_irq_o)
    );
endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk
    import guard_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int PULSE_LEN = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [BUS_DW-1:0] bus_wdata,
    input logic              wdt_rst_o,
    input logic              wdt_irq_o,
    input logic              en,
    input logic [CNT_W-1:0]  cnt
);
    logic kick_w, clr_a;
    assign kick_w = bus_sel && bus_wr && (bus_addr == OFS_KICK) && (bus_wdata == KICK_CODE);
    assign clr_a  = bus_sel && (bus_addr == OFS_CLR);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!wdt_rst_o && !wdt_irq_o)); // R1
    AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> en); // R2
    AST_PULSE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst_o) |-> (cnt == CNT_W'(PULSE_LEN - 1))); // R4
    AST_KICK_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_w && !wdt_rst_o) |=> !wdt_irq_o); // R5
    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_irq_o) |-> ($past(cnt) == '0)); // R6
    AST_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wdt_rst_o && wdt_irq_o)); // R6
    AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_irq_o && clr_a && !kick_w && (cnt != '0)) |=> !wdt_irq_o); // R7
    AST_KICK_BEATS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_w && !wdt_rst_o) |=> !wdt_rst_o); // R8
endmodule

bind guard_timer guard_timer_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .wdt_rst_o(wdt_rst_o),
    .wdt_irq_o(wdt_irq_o), .en(ctrl_en), .cnt(cnt_val)
);

// File: tb/guard_timer_tb_top.sv
module guard_timer_tb_top;
    localparam int BASE_EXP = 2;
    localparam int PULSE_LEN = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_rst_o, wdt_irq_o;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    guard_timer #(.BASE_EXP(BASE_EXP), .PULSE_LEN(PULSE_LEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_rst_o(wdt_rst_o), .wdt_irq_o(wdt_irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic skip(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        skip(3);
        rst_n = 1'b1;
        skip(1);
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        do_reset();
        check("R1 rst_o", 32'(wdt_rst_o), 0);
        check("R1 irq_o", 32'(wdt_irq_o), 0);
        bus_read(8'h00, d); check("R1 ctrl", d, 0);
        bus_read(8'h04, d); check("R1 range", d, 0);
        bus_read(8'h08, d); check("R1 count", d, 0);
        bus_read(8'h10, d); check("R1 status", d, 0);
        bus_read(8'hF4, d); check("R9 param", d, 32'h40);
        bus_read(8'h20, d); check("R9 unmapped", d, 0);
    endtask

    task automatic t_direct_mode();
        logic [31:0] d;
        do_reset();
        bus_write(8'h04, 32'h10);
        bus_read(8'h04, d); check("R9 range readback", d, 32'h10);
        bus_write(8'h00, 32'h1);               // k=0
        bus_read(8'h08, d); check("R3 initial load", d, 7); // k=1
        skip(6); check("R4 no reset before period", 32'(wdt_rst_o), 0);
        skip(1); check("R4 reset at expiry", 32'(wdt_rst_o), 1);
        skip(7); check("R4 pulse still high", 32'(wdt_rst_o), 1);
        skip(1); check("R4 pulse ended", 32'(wdt_rst_o), 0);
        bus_read(8'h08, d); check("R4 reload run period", d, 3); // k=17
        skip(2); check("R4 second period running", 32'(wdt_rst_o), 0);
        skip(1); check("R4 second reset", 32'(wdt_rst_o), 1);
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        do_reset();
        bus_write(8'h00, 32'h1);
        bus_write(8'h00, 32'h0);
        bus_read(8'h00, d); check("R2 enable sticky", d, 1);
        bus_write(8'h00, 32'h2);
        bus_read(8'h00, d); check("R2 mode writable", d, 3);
    endtask

    task automatic t_kick();
        logic [31:0] d;
        do_reset();
        bus_write(8'h04, 32'h22);
        bus_write(8'h00, 32'h1);               // count 15
        skip(5);                               // count 10
        bus_write(8'h0C, 32'h76);
        bus_read(8'h08, d); check("R5 kick reloads", d, 15);
        bus_write(8'h0C, 32'h77);
        bus_read(8'h08, d); check("R5 wrong code ignored", d, 13);
        bus_write(8'h08, 32'h0);
        bus_read(8'h08, d); check("R9 count write ignored", d, 11);
        bus_write(8'h0C, 32'h176);
        bus_read(8'h08, d); check("R5 upper bits disqualify", d, 9);
    endtask

    task automatic t_warn_mode();
        logic [31:0] d;
        do_reset();
        bus_write(8'h00, 32'h3);               // k=0, P=4
        skip(3);
        check("R6 no irq early", 32'(wdt_irq_o), 0);
        skip(1);
        check("R6 irq at first expiry", 32'(wdt_irq_o), 1);
        check("R6 no reset at first expiry", 32'(wdt_rst_o), 0);
        bus_read(8'h10, d); check("R6 status bit", d, 1); // k=5
        skip(2); check("R6 still waiting", 32'(wdt_rst_o), 0);
        skip(1);
        check("R6 reset at second expiry", 32'(wdt_rst_o), 1);
        check("R6 irq ends with pulse", 32'(wdt_irq_o), 0);
    endtask

    task automatic t_kick_and_clear();
        logic [31:0] d;
        do_reset();
        bus_write(8'h04, 32'h11);
        bus_write(8'h00, 32'h3);               // k=0, P=8
        skip(8); check("R6 irq P=8", 32'(wdt_irq_o), 1);
        bus_write(8'h0C, 32'h76);              // k=9
        check("R5 kick drops irq", 32'(wdt_irq_o), 0);
        skip(7); check("R5 first stage rearmed", 32'(wdt_irq_o), 0);
        skip(1);
        check("R5 irq again after kick", 32'(wdt_irq_o), 1);
        check("R5 no reset after kick", 32'(wdt_rst_o), 0);
        bus_write(8'h14, 32'h0);               // k=18, count 6
        check("R7 write clear", 32'(wdt_irq_o), 0);
        skip(6); check("R7 no reload on clear", 32'(wdt_irq_o), 0);
        skip(1);
        check("R7 first stage after clear", 32'(wdt_irq_o), 1);
        check("R7 no reset after clear", 32'(wdt_rst_o), 0);
        bus_read(8'h14, d); check("R7 read-clear data", d, 1);
        check("R7 read clear", 32'(wdt_irq_o), 0);
    endtask

    task automatic t_collisions();
        logic [31:0] d;
        do_reset();
        bus_write(8'h00, 32'h1);               // k=0, P=4
        skip(3);
        bus_write(8'h0C, 32'h76);              // edge k=4 = expiry edge
        check("R8 kick beats expiry", 32'(wdt_rst_o), 0);
        bus_read(8'h08, d); check("R8 kick reloaded", d, 3);
        skip(2); check("R8 full period follows", 32'(wdt_rst_o), 0);
        skip(1); check("R8 reset after period", 32'(wdt_rst_o), 1);
        do_reset();
        bus_write(8'h00, 32'h3);
        skip(4); check("R8 irq raised", 32'(wdt_irq_o), 1);
        skip(3);
        bus_write(8'h14, 32'h0);               // edge k=8 = second expiry
        check("R8 expiry beats clear", 32'(wdt_rst_o), 1);
    endtask

    initial begin
        t_reset_state();
        t_direct_mode();
        t_sticky();
        t_kick();
        t_warn_mode();
        t_kick_and_clear();
        t_collisions();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule